// File: doc/BRIEF.md
# Runahead Mode Controller

This block sits beside the retirement end of a simplified core and watches the oldest instruction in the window, one instruction per cycle. When that instruction is a load that has missed deep in the cache hierarchy, the core would otherwise sit idle with a full window. Instead, the controller saves a copy of the architectural registers and switches the core into a speculative mode. In that mode later instructions keep executing. Their results never become architectural, and any load with a trustworthy address turns into a data prefetch.

Every register has a poison flag. A result that depends on the outstanding miss, directly or through a chain of instructions, is flagged rather than written. A load whose base register is poisoned issues nothing, because its address is unknown; this is the pointer-chasing case.

When the triggering miss returns, the controller copies the saved registers back and clears every poison flag. For exactly one cycle it raises a pipeline flush and a fetch redirect to the PC of the load that missed. The core then resumes normal execution from that load.

The mode machine has three states. `ST_NORMAL` commits results. `ST_RUNAHEAD` executes speculatively. `ST_RESTORE` is a single cycle that restores the registers and asserts flush and redirect. The transitions are:
- `ST_NORMAL` to `ST_RUNAHEAD` when a valid load at the head reports a miss.
- `ST_RUNAHEAD` to `ST_RESTORE` when `miss_return` is high.
- `ST_RESTORE` to `ST_NORMAL` unconditionally.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the block is in normal mode, flush, redirect and prefetch outputs are low, and every register reads value 0 with its poison flag (`rd_inv`) clear.
- R2: In normal mode an accepted instruction with `head_dst_we` writes `head_result` into register `head_dst`; the value is visible on `rd_data` the cycle after, with `rd_inv` = 0.
- R3: Speculative mode (`mode_runahead` = 1, starting the cycle after) is entered only from normal mode, and only when `head_valid`, `head_is_load` and `head_miss` are all 1. A non-load with `head_miss` set, or a load without it, does not enter.
- R4: Register values seen after a speculative episode equal those just before the triggering load. Neither the triggering load nor anything executed in speculative mode changes them.
- R5: A written destination is poisoned exactly when an enabled source (`head_src1_en`/`head_src1`, `head_src2_en`/`head_src2`) is poisoned, or when the instruction is a missing load. Otherwise it takes `head_result` and its poison flag clears. The triggering load poisons its own destination.
- R6: In speculative mode, an accepted load whose base (source 1) is not poisoned raises `pf_valid` the following cycle with `pf_addr` = `head_addr`. No prefetch is ever issued in normal mode.
- R7: A speculative load whose enabled base register is poisoned issues no prefetch.
- R8: A load that misses while already in speculative mode issues its prefetch, poisons its destination, and leaves the block in speculative mode.
- R9: The cycle after `miss_return` is seen in speculative mode, `flush` and `redirect_valid` are high for exactly one cycle with `redirect_pc` equal to the triggering load's PC. The cycle after that the block is in normal mode with all poison flags clear.
- R10: `miss_return` in normal mode has no effect, and an instruction presented in the `miss_return` cycle or in the restore cycle changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Oldest instruction is presented this cycle |
| head_is_load | input | 1 | Head instruction is a load |
| head_miss | input | 1 | Head load is a long-latency miss |
| head_pc | input | PC_W | PC of the head instruction |
| head_dst | input | IDX_W | Destination register index |
| head_dst_we | input | 1 | Head instruction writes a register |
| head_src1 | input | IDX_W | Source 1 index (load base) |
| head_src1_en | input | 1 | Source 1 is used |
| head_src2 | input | IDX_W | Source 2 index |
| head_src2_en | input | 1 | Source 2 is used |
| head_result | input | DATA_W | Result value of the head instruction |
| head_addr | input | ADDR_W | Load address |
| miss_return | input | 1 | The triggering miss has returned |
| rd_idx | input | IDX_W | Register observation index |
| rd_data | output | DATA_W | Current value of register `rd_idx` |
| rd_inv | output | 1 | Poison flag of register `rd_idx` |
| mode_runahead | output | 1 | Block is in speculative mode |
| flush | output | 1 | Pipeline flush pulse |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | PC_W | Redirect target (triggering load PC) |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
The hardest situation to reach from the ports is a long speculative episode in which poison has spread through chains of instructions and then been overwritten again by clean results. After that, the restore must still reproduce the pre-trigger register values exactly.

A directed sequence builds such a chain deliberately. It includes a poisoned base feeding a load, a second miss inside speculative mode, an instruction arriving together with `miss_return`, and another arriving in the restore cycle.

A long random phase follows, driven against a behavioural model. In that phase misses trigger episodes of random length, with mixed dependent traffic, and `rd_idx` is swept across the whole register file.

// File: rtl/runahead_pkg.sv
package runahead_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_RUNAHEAD = 2'd1,
        ST_RESTORE  = 2'd2
    } ra_state_e;

endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
    import runahead_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trigger,
    input  logic            miss_return,
    input  logic [PC_W-1:0] head_pc,
    output ra_state_e       state,
    output logic            enter,
    output logic            flush,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);

    ra_state_e       state_q, state_d;
    logic [PC_W-1:0] trig_pc_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // remember which load started the episode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_pc_q <= '0;
        end else if (enter) begin
            trig_pc_q <= head_pc;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:   if (trigger)     state_d = ST_RUNAHEAD;
            ST_RUNAHEAD: if (miss_return) state_d = ST_RESTORE;
            ST_RESTORE:                   state_d = ST_NORMAL;
            default:                      state_d = ST_NORMAL;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        enter          = 1'b0;
        flush          = 1'b0;
        redirect_valid = 1'b0;
        unique case (state_q)
            ST_NORMAL:   enter = trigger;
            ST_RUNAHEAD: enter = 1'b0;
            ST_RESTORE: begin
                flush          = 1'b1;
                redirect_valid = 1'b1;
            end
            default:     enter = 1'b0;
        endcase
    end

    assign state       = state_q;
    assign redirect_pc = trig_pc_q;

endmodule

// File: rtl/ra_regfile.sv
module ra_regfile #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_poison,
    input  logic              ckpt_take,
    input  logic              ckpt_restore,
    input  logic [IDX_W-1:0]  src1_idx,
    input  logic [IDX_W-1:0]  src2_idx,
    output logic              src1_inv,
    output logic              src2_inv,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_inv
);

    logic [DATA_W-1:0] val_bus [NUM_REGS];
    logic [NUM_REGS-1:0] inv_bus;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        logic [DATA_W-1:0] saved_q;
        logic              inv_q;
        logic              hit;

        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q   <= '0;
                saved_q <= '0;
                inv_q   <= 1'b0;
            end else if (ckpt_restore) begin
                val_q <= saved_q;
                inv_q <= 1'b0;
            end else begin
                if (ckpt_take) begin
                    saved_q <= val_q;
                end
                if (hit) begin
                    inv_q <= wr_poison;
                    if (!wr_poison) begin
                        val_q <= wr_data;
                    end
                end
            end
        end

        assign val_bus[g] = val_q;
        assign inv_bus[g] = inv_q;
    end

    assign src1_inv = inv_bus[src1_idx];
    assign src2_inv = inv_bus[src2_idx];
    assign rd_data  = val_bus[rd_idx];
    assign rd_inv   = inv_bus[rd_idx];

endmodule

// File: rtl/ra_pf_filter.sv
module ra_pf_filter #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_runahead,
    input  logic              accept,
    input  logic              is_load,
    input  logic              base_en,
    input  logic              base_inv,
    input  logic [ADDR_W-1:0] addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    logic issue;

    assign issue = in_runahead && accept && is_load && !(base_en && base_inv);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= issue;
            if (issue) begin
                pf_addr <= addr;
            end
        end
    end

endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
    import runahead_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int PC_W     = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic              head_is_load,
    input  logic              head_miss,
    input  logic [PC_W-1:0]   head_pc,
    input  logic [IDX_W-1:0]  head_dst,
    input  logic              head_dst_we,
    input  logic [IDX_W-1:0]  head_src1,
    input  logic              head_src1_en,
    input  logic [IDX_W-1:0]  head_src2,
    input  logic              head_src2_en,
    input  logic [DATA_W-1:0] head_result,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic              miss_return,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_inv,
    output logic              mode_runahead,
    output logic              flush,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    ra_state_e state;
    logic      enter;
    logic      trigger;
    logic      accept;
    logic      poison;
    logic      src1_inv;
    logic      src2_inv;
    logic      in_ra;
    logic      in_restore;

    assign trigger    = head_valid && head_is_load && head_miss;
    assign in_ra      = (state == ST_RUNAHEAD);
    assign in_restore = (state == ST_RESTORE);

    // instructions are taken in normal mode, or speculatively until the miss returns
    assign accept = head_valid && ((state == ST_NORMAL) || (in_ra && !miss_return));

    // a result is poisoned by a poisoned operand or by being a missing load itself
    assign poison = (head_src1_en && src1_inv) ||
                    (head_src2_en && src2_inv) ||
                    (head_is_load && head_miss);

    ra_mode_fsm #(
        .PC_W (PC_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .trigger        (trigger),
        .miss_return    (miss_return),
        .head_pc        (head_pc),
        .state          (state),
        .enter          (enter),
        .flush          (flush),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    ra_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (accept && head_dst_we),
        .wr_idx       (head_dst),
        .wr_data      (head_result),
        .wr_poison    (poison),
        .ckpt_take    (enter),
        .ckpt_restore (in_restore),
        .src1_idx     (head_src1),
        .src2_idx     (head_src2),
        .src1_inv     (src1_inv),
        .src2_inv     (src2_inv),
        .rd_idx       (rd_idx),
        .rd_data      (rd_data),
        .rd_inv       (rd_inv)
    );

    ra_pf_filter #(
        .ADDR_W (ADDR_W)
    ) u_pf (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_runahead (in_ra),
        .accept      (accept),
        .is_load     (head_is_load),
        .base_en     (head_src1_en),
        .base_inv    (src1_inv),
        .addr        (head_addr),
        .pf_valid    (pf_valid),
        .pf_addr     (pf_addr)
    );

    assign mode_runahead = in_ra;

endmodule

// File: rtl/ra_ctrl_checker.sv
module ra_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_runahead,
    input logic flush,
    input logic pf_valid,
    input logic miss_return,
    input logic head_valid,
    input logic head_is_load,
    input logic head_miss,
    input logic head_src1_en,
    input logic base_inv
);

    // R3
    entry_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_runahead) |-> $past(head_valid && head_is_load && head_miss));

    // R6
    pf_only_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(mode_runahead));

    // R7
    poisoned_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_runahead && !miss_return && head_valid && head_is_load &&
         head_src1_en && base_inv) |=> !pf_valid);

    // R9
    return_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_runahead && miss_return) |=> flush);

    // R9
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!flush && !mode_runahead));

endmodule

bind runahead_ctrl ra_ctrl_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_runahead (mode_runahead),
    .flush         (flush),
    .pf_valid      (pf_valid),
    .miss_return   (miss_return),
    .head_valid    (head_valid),
    .head_is_load  (head_is_load),
    .head_miss     (head_miss),
    .head_src1_en  (head_src1_en),
    .base_inv      (src1_inv)
);

// File: tb/test_runahead_ctrl.sv
module test_runahead_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        head_valid = 0, head_is_load = 0, head_miss = 0, head_dst_we = 0;
    logic        head_src1_en = 0, head_src2_en = 0, miss_return = 0;
    logic [31:0] head_pc = 0, head_result = 0, head_addr = 0;
    logic [3:0]  head_dst = 0, head_src1 = 0, head_src2 = 0, rd_idx = 0;
    logic [31:0] rd_data, redirect_pc, pf_addr;
    logic        rd_inv, mode_runahead, flush, redirect_valid, pf_valid;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    int          m_state;
    logic [31:0] m_regs [16];
    logic [31:0] m_ckpt [16];
    bit          m_inv  [16];
    logic [31:0] m_pc;
    bit          m_pf_v;
    logic [31:0] m_pf_a;

    always #2 clk = ~clk;

    runahead_ctrl i_runahead_ctrl (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_is_load(head_is_load),
        .head_miss(head_miss), .head_pc(head_pc), .head_dst(head_dst), .head_dst_we(head_dst_we),
        .head_src1(head_src1), .head_src1_en(head_src1_en), .head_src2(head_src2),
        .head_src2_en(head_src2_en), .head_result(head_result), .head_addr(head_addr),
        .miss_return(miss_return), .rd_idx(rd_idx), .rd_data(rd_data), .rd_inv(rd_inv),
        .mode_runahead(mode_runahead), .flush(flush), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pc = 0; m_pf_v = 0; m_pf_a = 0;
            for (int i = 0; i < 16; i++) begin m_regs[i] = 0; m_ckpt[i] = 0; m_inv[i] = 0; end
        end else begin
            bit acc, p;
            acc = head_valid && (m_state == 0 || (m_state == 1 && !miss_return));
            m_pf_v = (m_state == 1) && acc && head_is_load && !(head_src1_en && m_inv[head_src1]);
            if (m_pf_v) m_pf_a = head_addr;
            if (m_state == 2) begin
                for (int i = 0; i < 16; i++) begin m_regs[i] = m_ckpt[i]; m_inv[i] = 0; end
                m_state = 0;
            end else begin
                if (m_state == 0 && head_valid && head_is_load && head_miss) begin
                    for (int i = 0; i < 16; i++) m_ckpt[i] = m_regs[i];
                    m_pc = head_pc;
                    m_state = 1;
                end else if (m_state == 1 && miss_return) begin
                    m_state = 2;
                end
                if (acc && head_dst_we) begin
                    p = (head_src1_en && m_inv[head_src1]) || (head_src2_en && m_inv[head_src2]) ||
                        (head_is_load && head_miss);
                    m_inv[head_dst] = p;
                    if (!p) m_regs[head_dst] = head_result;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3 mode", 32'(mode_runahead), 32'(m_state == 1));
        chk("R9 flush", 32'(flush), 32'(m_state == 2));
        chk("R9 redirect_valid", 32'(redirect_valid), 32'(m_state == 2));
        if (m_state == 2) chk("R9 redirect_pc", redirect_pc, m_pc);
        chk("R6 pf_valid", 32'(pf_valid), 32'(m_pf_v));
        if (m_pf_v) chk("R6 pf_addr", pf_addr, m_pf_a);
        chk("R4 rd_data", rd_data, m_regs[rd_idx]);
        chk("R5 rd_inv", 32'(rd_inv), 32'(m_inv[rd_idx]));
    endtask

    task automatic instr(bit v, bit ld, bit ms, logic [3:0] dst, bit we,
                         logic [3:0] s1, bit s1e, logic [3:0] s2, bit s2e,
                         logic [31:0] data, logic [31:0] addr, logic [31:0] pc,
                         bit mret, logic [3:0] rd);
        head_valid = v; head_is_load = ld; head_miss = ms; head_dst = dst; head_dst_we = we;
        head_src1 = s1; head_src1_en = s1e; head_src2 = s2; head_src2_en = s2e;
        head_result = data; head_addr = addr; head_pc = pc; miss_return = mret; rd_idx = rd;
        @(negedge clk);
        compare_all();
        head_valid = 0; miss_return = 0;
    endtask

    task automatic idle(logic [3:0] rd);
        instr(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mode", 32'(mode_runahead), 0);
        chk("R1 flush", 32'(flush), 0);
        chk("R1 pf", 32'(pf_valid), 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 rd_inv", 32'(rd_inv), 0);

        // R2 normal commits
        instr(1, 0, 0, 1, 1, 0, 0, 0, 0, 32'h100, 0, 32'h10, 0, 1);
        chk("R2 r1 value", rd_data, 32'h100);
        instr(1, 0, 0, 2, 1, 1, 1, 0, 0, 32'h200, 0, 32'h14, 0, 2);
        instr(1, 1, 0, 3, 1, 1, 1, 0, 0, 32'h333, 32'h800, 32'h18, 0, 3);
        chk("R2 load hit value", rd_data, 32'h333);
        // R3 non-load with miss flag, and load hit, stay normal
        instr(1, 0, 1, 5, 1, 0, 0, 0, 0, 32'h55, 0, 32'h1c, 0, 5);
        chk("R3 alu miss flag", 32'(mode_runahead), 0);
        // R3 trigger
        instr(1, 1, 1, 4, 1, 1, 1, 0, 0, 32'hfff, 32'h900, 32'h40, 0, 4);
        chk("R3 entered", 32'(mode_runahead), 1);
        chk("R5 trigger dst poisoned", 32'(rd_inv), 1);
        // R5 valid speculative result
        instr(1, 0, 0, 5, 1, 1, 1, 2, 1, 32'h555, 0, 32'h44, 0, 5);
        chk("R5 clean spec value", rd_data, 32'h555);
        // R5 dependent on poisoned
        instr(1, 0, 0, 6, 1, 4, 1, 0, 0, 32'h666, 0, 32'h48, 0, 6);
        chk("R5 chain poisoned", 32'(rd_inv), 1);
        // R6 prefetch
        instr(1, 1, 0, 7, 1, 1, 1, 0, 0, 32'h777, 32'h1000, 32'h4c, 0, 7);
        chk("R6 pf issued", 32'(pf_valid), 1);
        chk("R6 pf addr", pf_addr, 32'h1000);
        // R7 poisoned base
        instr(1, 1, 0, 8, 1, 6, 1, 0, 0, 32'h888, 32'h1800, 32'h50, 0, 8);
        chk("R7 no pf", 32'(pf_valid), 0);
        chk("R7 dst poisoned", 32'(rd_inv), 1);
        // R8 miss inside runahead
        instr(1, 1, 1, 9, 1, 2, 1, 0, 0, 32'h999, 32'h2000, 32'h54, 0, 9);
        chk("R8 pf", 32'(pf_valid), 1);
        chk("R8 still spec", 32'(mode_runahead), 1);
        chk("R8 dst poisoned", 32'(rd_inv), 1);
        // R5 poison cleared by clean overwrite
        instr(1, 0, 0, 6, 1, 2, 1, 0, 0, 32'h600, 0, 32'h58, 0, 6);
        chk("R5 poison cleared", 32'(rd_inv), 0);
        instr(1, 0, 0, 1, 1, 0, 0, 0, 0, 32'hdead, 0, 32'h5c, 0, 1);
        // R9 return with an instruction (R10 dropped)
        instr(1, 0, 0, 2, 1, 0, 0, 0, 0, 32'hbad, 0, 32'h60, 1, 2);
        chk("R9 flush", 32'(flush), 1);
        chk("R9 redirect", redirect_pc, 32'h40);
        // R10 instruction during restore cycle is dropped
        instr(1, 0, 0, 3, 1, 0, 0, 0, 0, 32'h999, 0, 32'h64, 0, 1);
        chk("R4 r1 restored", rd_data, 32'h100);
        chk("R9 back to normal", 32'(mode_runahead | flush), 0);
        idle(3);
        chk("R10 restore cycle dropped", rd_data, 32'h333);
        idle(2);
        chk("R10 return cycle dropped", rd_data, 32'h200);
        idle(4);
        chk("R9 poison cleared", 32'(rd_inv), 0);
        // R10 miss_return in normal
        instr(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R10 stray return", 32'(mode_runahead | flush), 0);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            int r;
            bit ld, ms, mr;
            r  = $urandom_range(0, 99);
            ld = (r < 40);
            ms = ld ? ($urandom_range(0, 99) < 12) : ($urandom_range(0, 99) < 5);
            mr = (m_state == 1) ? ($urandom_range(0, 99) < 10) : ($urandom_range(0, 99) < 3);
            instr($urandom_range(0, 99) < 80, ld, ms, 4'($urandom), $urandom_range(0, 99) < 85,
                  4'($urandom), $urandom_range(0, 1) == 1, 4'($urandom), $urandom_range(0, 1) == 1,
                  $urandom, $urandom, $urandom, mr, 4'(c));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule